// File: doc/BRIEF.md
# Scan Delay Test Sequencer

This block runs a two-vector delay test on a scan chain. After a start request it puts every scan flip-flop in shift mode and serially loads the first state vector V1 on a slow derived clock. It then forms the second vector V2 in one of two ways. In shift launch, the chain is clocked one more time in shift mode. In functional launch, the chain is clocked once in normal mode. Exactly one rated period after that launch edge, the block clocks the chain once in normal mode to capture the response. Finally it shifts the response back out on the slow clock, collects it into a parallel word and pulses a done flag.

All timing is counted in ticks of a free-running reference clock. The derived test clock `tclk` is built from slots. Each slot holds its rising edge one tick after the slot begins, stays high for half the rated period, then stays low until the slot ends. Load, capture and unload slots last `SLOW_TICKS`. Only the launch slot lasts `RATED_TICKS`, so the launch-to-capture interval is the rated period while all shifting runs slowly. The test-control line, the serial data and the primary-input word change only at times when `tclk` is low. The primary-input word holds V1 up to the launch edge and V2 from the falling half of the launch pulse.

Top module: `scan_delay_seq`

## Requirements
- R1: Out of reset the block is idle with `test_mode` = 1 (scan), `tclk` = 0, `done` = 0 and no `tclk` edges until a start is seen.
- R2: After start, the first `CHAIN_LEN` rising `tclk` edges occur with `test_mode` = 1, are spaced `SLOW_TICKS` ticks apart, and shift `v1_bits[CHAIN_LEN-1]` first, so that after loading, chain flop i holds `v1_bits[i]` (flop 0 is at `chain_si`, flop `CHAIN_LEN-1` drives `chain_so`).
- R3: With `launch_func` = 0, the launch edge (edge number `CHAIN_LEN`+1) comes `SLOW_TICKS` after the last load edge, with `test_mode` = 1 and `chain_si` = `shift_fill`, so V2 = {V1 shifted up one place, `shift_fill` in flop 0}.
- R4: With `launch_func` = 1, the launch edge comes with `test_mode` = 0, so V2 is the logic's next state from V1 and `pi_first`.
- R5: The capture edge follows the launch edge by exactly `RATED_TICKS` ticks, with `test_mode` = 0.
- R6: `pi_drive` equals `pi_first` at the launch edge and `pi_second` at the capture edge.
- R7: After capture, `CHAIN_LEN` further edges with `test_mode` = 1 shift the chain out, and `resp` then equals the captured state with bit i = flop i.
- R8: `test_mode` and `pi_drive` change only when `tclk` is low both in the current tick and in the tick before.
- R9: `done` is high for exactly one tick after the last unload slot, and a test produces exactly 2·`CHAIN_LEN`+2 rising `tclk` edges and none afterwards.
- R10: A start request while a test is running is ignored: the running test completes with its original pattern and no second test follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all periods are counted in its ticks |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request, sampled only when idle |
| launch_func | input | 1 | 0 = shift launch, 1 = functional launch |
| v1_bits | input | CHAIN_LEN | Scan state of the first vector, bit i for flop i |
| pi_first | input | PI_W | Primary-input values for V1 |
| pi_second | input | PI_W | Primary-input values for V2 |
| shift_fill | input | 1 | Bit shifted into flop 0 by the shift launch |
| chain_so | input | 1 | Serial output of the last chain flop |
| test_mode | output | 1 | 1 = scan shift, 0 = normal capture, for every chain flop |
| tclk | output | 1 | Gated test clock for the chain |
| chain_si | output | 1 | Serial input to flop 0 |
| pi_drive | output | PI_W | Primary-input word applied to the logic under test |
| resp | output | CHAIN_LEN | Unloaded response, valid when done pulses |
| done | output | 1 | One-tick pulse at the end of a test |

## Verification
If the slot length were chosen wrongly, or the phase counter slipped, it would show directly as a wrong spacing between rising `tclk` edges. The gap between the two edges around capture would differ from the rated period one slot after the launch. A state machine that stepped through the slots in the wrong order, or too many or too few times, would give a wrong edge count or a wrong `test_mode` level at some edge. That shows up by the end of the same test. Mistakes in the serial order, the fill bit or the choice of launch mode only become visible when `resp` is read at the done pulse. There it differs from the response that the bench computes from its own model of the chain and the logic.

// File: rtl/sdt_pkg.sv
package sdt_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOAD,
      ST_LAUNCH,
      ST_CAPT,
      ST_UNLOAD
   } sdt_state_e;

   localparam logic LAUNCH_SHIFT = 1'b0;
   localparam logic LAUNCH_FUNC  = 1'b1;
endpackage

// File: rtl/sdt_clkgen.sv
module sdt_clkgen #(
   parameter int SLOW_TICKS  = 10,
   parameter int RATED_TICKS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic fast,
   output logic tclk,
   output logic slot_end,
   output logic settle
);
   localparam int PW = $clog2(SLOW_TICKS + 1);
   localparam int HI = RATED_TICKS / 2;

   logic [PW-1:0] ph, ph_nx, len_m1;

   assign len_m1   = fast ? PW'(RATED_TICKS - 1) : PW'(SLOW_TICKS - 1);
   assign slot_end = run && (ph == len_m1);
   assign settle   = run && (ph == PW'(HI + 1));
   assign ph_nx    = (!run || slot_end) ? '0 : ph + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph   <= '0;
         tclk <= 1'b0;
      end else begin
         ph   <= ph_nx;
         tclk <= run && (ph_nx >= PW'(1)) && (ph_nx <= PW'(HI));
      end
   end

   // R8: every slot boundary falls in the low part of the clock
   p_low_at_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
      slot_end |-> !tclk);
   // R9: clock stays parked low while not running
   p_parked_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !tclk);
endmodule

// File: rtl/sdt_ctrl.sv
module sdt_ctrl
   import sdt_pkg::*;
#(
   parameter int CHAIN_LEN = 8,
   parameter int PI_W      = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 launch_func,
   input  logic [CHAIN_LEN-1:0] v1_bits,
   input  logic [PI_W-1:0]      pi_first,
   input  logic [PI_W-1:0]      pi_second,
   input  logic                 shift_fill,
   input  logic                 slot_end,
   input  logic                 settle,
   output sdt_state_e           state,
   output logic                 run,
   output logic                 fast,
   output logic                 test_mode,
   output logic                 chain_si,
   output logic [PI_W-1:0]      pi_drive,
   output logic                 done
);
   localparam int IW = $clog2(CHAIN_LEN);
   localparam logic [IW-1:0] LAST = IW'(CHAIN_LEN - 1);

   sdt_state_e           st;
   logic [IW-1:0]        idx;
   logic [CHAIN_LEN-1:0] v1_sr;
   logic                 mode_q, fill_q;
   logic [PI_W-1:0]      pi2_q, pi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         idx    <= '0;
         v1_sr  <= '0;
         mode_q <= LAUNCH_SHIFT;
         fill_q <= 1'b0;
         pi2_q  <= '0;
         pi_q   <= '0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (st)
            ST_IDLE: if (start) begin
               st     <= ST_LOAD;
               idx    <= '0;
               v1_sr  <= v1_bits;
               mode_q <= launch_func;
               fill_q <= shift_fill;
               pi_q   <= pi_first;
               pi2_q  <= pi_second;
            end
            ST_LOAD: if (slot_end) begin
               v1_sr <= v1_sr << 1;
               if (idx == LAST) st <= ST_LAUNCH;
               else             idx <= idx + 1'b1;
            end
            ST_LAUNCH: begin
               if (settle)   pi_q <= pi2_q;
               if (slot_end) st   <= ST_CAPT;
            end
            ST_CAPT: if (slot_end) begin
               st  <= ST_UNLOAD;
               idx <= '0;
            end
            ST_UNLOAD: if (slot_end) begin
               if (idx == LAST) begin
                  st   <= ST_IDLE;
                  done <= 1'b1;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign state     = st;
   assign run       = (st != ST_IDLE);
   assign fast      = (st == ST_LAUNCH);
   assign pi_drive  = pi_q;
   assign test_mode = (st == ST_IDLE) || (st == ST_LOAD) || (st == ST_UNLOAD) ||
                      ((st == ST_LAUNCH) && (mode_q == LAUNCH_SHIFT));
   assign chain_si  = (st == ST_LOAD)   ? v1_sr[CHAIN_LEN-1] :
                      (st == ST_LAUNCH) ? fill_q : 1'b0;

   // R10: a request during a running test leaves the latched pattern alone
   p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (run && start) |=> ($stable(pi2_q) && $stable(mode_q) && $stable(fill_q)));
   // R9: done is a single-tick pulse
   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R6: V1 inputs held for the whole load phase
   p_pi_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_LOAD && $past(st) == ST_LOAD) |-> $stable(pi_q));
endmodule

// File: rtl/sdt_unload.sv
module sdt_unload #(
   parameter int CHAIN_LEN = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clear,
   input  logic                 sample,
   input  logic                 chain_so,
   input  logic                 finish,
   output logic [CHAIN_LEN-1:0] resp
);
   localparam int CW = $clog2(CHAIN_LEN + 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         resp <= '0;
      end else if (clear) begin
         cnt  <= '0;
         resp <= '0;
      end else if (sample && (cnt < CW'(CHAIN_LEN))) begin
         resp <= {resp[CHAIN_LEN-2:0], chain_so};
         cnt  <= cnt + 1'b1;
      end
   end

   // R7: every chain bit has been collected when the test finishes
   p_all_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
      finish |-> (cnt == CW'(CHAIN_LEN)));
endmodule

// File: rtl/scan_delay_seq.sv
module scan_delay_seq
   import sdt_pkg::*;
#(
   parameter int CHAIN_LEN   = 8,
   parameter int PI_W        = 4,
   parameter int SLOW_TICKS  = 10,
   parameter int RATED_TICKS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 launch_func,
   input  logic [CHAIN_LEN-1:0] v1_bits,
   input  logic [PI_W-1:0]      pi_first,
   input  logic [PI_W-1:0]      pi_second,
   input  logic                 shift_fill,
   input  logic                 chain_so,
   output logic                 test_mode,
   output logic                 tclk,
   output logic                 chain_si,
   output logic [PI_W-1:0]      pi_drive,
   output logic [CHAIN_LEN-1:0] resp,
   output logic                 done
);
   localparam int GW = $clog2(SLOW_TICKS + 2);

   generate
      if (CHAIN_LEN < 2) begin : g_bad_len
         $error("CHAIN_LEN must be at least 2");
      end
      if (PI_W < 1) begin : g_bad_pi
         $error("PI_W must be at least 1");
      end
      if (RATED_TICKS < 4) begin : g_bad_rated
         $error("RATED_TICKS must be at least 4");
      end
      if (SLOW_TICKS <= RATED_TICKS) begin : g_bad_slow
         $error("SLOW_TICKS must exceed RATED_TICKS");
      end
   endgenerate

   sdt_state_e state;
   logic       run, fast, slot_end, settle;

   sdt_ctrl #(.CHAIN_LEN(CHAIN_LEN), .PI_W(PI_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .launch_func(launch_func),
      .v1_bits(v1_bits), .pi_first(pi_first), .pi_second(pi_second),
      .shift_fill(shift_fill), .slot_end(slot_end), .settle(settle),
      .state(state), .run(run), .fast(fast), .test_mode(test_mode),
      .chain_si(chain_si), .pi_drive(pi_drive), .done(done)
   );

   sdt_clkgen #(.SLOW_TICKS(SLOW_TICKS), .RATED_TICKS(RATED_TICKS)) u_clk (
      .clk(clk), .rst_n(rst_n), .run(run), .fast(fast), .tclk(tclk),
      .slot_end(slot_end), .settle(settle)
   );

   sdt_unload #(.CHAIN_LEN(CHAIN_LEN)) u_unl (
      .clk(clk), .rst_n(rst_n),
      .clear((state == ST_IDLE) && start),
      .sample(settle && ((state == ST_CAPT) || (state == ST_UNLOAD))),
      .chain_so(chain_so), .finish(done), .resp(resp)
   );

   // edge spacing monitor for the rated-interval property
   logic          tclk_d;
   logic [GW-1:0] gap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tclk_d <= 1'b0;
         gap    <= '0;
      end else begin
         tclk_d <= tclk;
         if (tclk && !tclk_d)  gap <= GW'(1);
         else if (gap != '1)   gap <= gap + 1'b1;
      end
   end

   // R5: capture edge sits one rated period after the launch edge
   p_rated_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tclk && !tclk_d && state == ST_CAPT) |-> (gap == GW'(RATED_TICKS)));
   // R8: control line moves only with the clock low
   p_mode_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(test_mode) |-> (!tclk && !$past(tclk)));
   // R8: primary inputs move only with the clock low
   p_pi_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pi_drive) |-> (!tclk && !$past(tclk)));
endmodule

// File: tb/sim_scan_delay_seq.sv
module sim_scan_delay_seq;
   localparam int N     = 8;
   localparam int PW    = 4;
   localparam int SLOW  = 10;
   localparam int RATED = 4;
   localparam time TCK  = 10ns;

   logic          clk = 1'b0, rst_n = 1'b0, start = 1'b0, launch_func = 1'b0;
   logic [N-1:0]  v1_bits = '0;
   logic [PW-1:0] pi_first = '0, pi_second = '0;
   logic          shift_fill = 1'b0;
   logic          chain_so, test_mode, tclk, chain_si, done;
   logic [PW-1:0] pi_drive;
   logic [N-1:0]  resp;

   int checks = 0, fails = 0;

   always #(TCK / 2) clk = ~clk;

   scan_delay_seq #(.CHAIN_LEN(N), .PI_W(PW), .SLOW_TICKS(SLOW), .RATED_TICKS(RATED)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .launch_func(launch_func),
      .v1_bits(v1_bits), .pi_first(pi_first), .pi_second(pi_second),
      .shift_fill(shift_fill), .chain_so(chain_so), .test_mode(test_mode),
      .tclk(tclk), .chain_si(chain_si), .pi_drive(pi_drive), .resp(resp), .done(done)
   );

   // logic under test: next state from state and primary inputs
   function automatic logic [N-1:0] cut_next(logic [N-1:0] s, logic [PW-1:0] p);
      return {s[N-2:0], s[N-1]} ^ (s >> 3) ^ {{(N-PW){1'b0}}, p} ^ {p[0], {(N-1){1'b0}}};
   endfunction

   // scan chain model: flop 0 at chain_si, flop N-1 drives chain_so
   logic [N-1:0] chain = '0;
   always @(posedge tclk) begin
      if (test_mode) chain <= {chain[N-2:0], chain_si};
      else           chain <= cut_next(chain, pi_drive);
   end
   assign chain_so = chain[N-1];

   // port monitor
   int            cyc = 0, nr = 0, glitch = 0, done_cnt = 0;
   int            rise_cyc [64];
   logic          rise_te  [64];
   logic [PW-1:0] rise_pi  [64];
   logic          tclk_p = 1'b0, te_p = 1'b1;
   logic [PW-1:0] pi_p = '0;

   always @(negedge clk) begin
      cyc++;
      if (tclk && !tclk_p && nr < 64) begin
         rise_cyc[nr] = cyc;
         rise_te[nr]  = test_mode;
         rise_pi[nr]  = pi_drive;
         nr++;
      end
      if (rst_n && ((test_mode !== te_p) || (pi_drive !== pi_p)) && (tclk || tclk_p))
         glitch++;
      if (done) done_cnt++;
      tclk_p = tclk;
      te_p   = test_mode;
      pi_p   = pi_drive;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic run_test(input logic mode, input logic [N-1:0] v1,
                           input logic [PW-1:0] p1, input logic [PW-1:0] p2,
                           input logic fill, input bit intrude);
      logic [N-1:0] v2, cap;
      int bad_gap, bad_te, nr_done;
      @(negedge clk);
      nr = 0; glitch = 0; done_cnt = 0;
      launch_func = mode; v1_bits = v1; pi_first = p1; pi_second = p2; shift_fill = fill;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (intrude) begin
         repeat (3 * SLOW) @(negedge clk);
         launch_func = ~mode; v1_bits = ~v1; pi_first = ~p1; pi_second = ~p2;
         shift_fill = ~fill; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      for (int w = 0; w < 4000; w++) begin
         @(negedge clk);
         if (done) break;
      end
      repeat (3) @(negedge clk);
      nr_done = nr;
      v2  = mode ? cut_next(v1, p1) : {v1[N-2:0], fill};
      cap = cut_next(v2, p2);
      if (mode) chk(resp == cap, "R4", "functional-launch response", resp, cap);
      else      chk(resp == cap, "R3", "shift-launch response", resp, cap);
      chk(resp == cap, "R7", "unloaded word", resp, cap);
      if (intrude) chk(resp == cap, "R10", "response after ignored start", resp, cap);
      chk(nr_done == 2 * N + 2, "R9", "edge count", nr_done, 2 * N + 2);
      chk(done_cnt == 1, "R9", "done width", done_cnt, 1);
      bad_gap = 0; bad_te = 0;
      for (int i = 0; i + 1 < nr_done && i + 1 < 64; i++) begin
         if (i != N && rise_cyc[i+1] - rise_cyc[i] != SLOW) bad_gap++;
      end
      for (int i = 0; i < nr_done && i < 64; i++) begin
         if (i < N && rise_te[i] !== 1'b1) bad_te++;
         if (i > N + 1 && rise_te[i] !== 1'b1) bad_te++;
      end
      chk(bad_gap == 0, "R2", "slow spacing mismatches", bad_gap, 0);
      chk(bad_te == 0, "R2", "scan level on shift edges", bad_te, 0);
      if (nr_done > N + 1) begin
         chk(rise_cyc[N+1] - rise_cyc[N] == RATED, "R5", "launch-capture ticks",
             rise_cyc[N+1] - rise_cyc[N], RATED);
         chk(rise_te[N+1] == 1'b0, "R5", "mode at capture", rise_te[N+1], 0);
         chk(rise_te[N] == !mode, mode ? "R4" : "R3", "mode at launch", rise_te[N], !mode);
         chk(rise_pi[N] == p1, "R6", "inputs at launch", rise_pi[N], p1);
         chk(rise_pi[N+1] == p2, "R6", "inputs at capture", rise_pi[N+1], p2);
      end
      chk(glitch == 0, "R8", "changes while clock high", glitch, 0);
      repeat (2 * SLOW) @(negedge clk);
      chk(nr == nr_done, "R10", "edges after done", nr, nr_done);
      chk(tclk == 1'b0 && test_mode == 1'b1, "R1", "idle levels after test",
          {tclk, test_mode}, 2'b01);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (5) @(negedge clk);
      chk(tclk == 1'b0, "R1", "tclk in reset", tclk, 0);
      chk(test_mode == 1'b1 && done == 1'b0, "R1", "mode/done in reset",
          {test_mode, done}, 2'b10);
      rst_n = 1'b1;
      repeat (3 * SLOW) @(negedge clk);
      chk(nr == 0, "R1", "no edges before start", nr, 0);
      // directed corners
      run_test(1'b0, '0, 4'h0, 4'hF, 1'b1, 1'b0);
      run_test(1'b0, '1, 4'hF, 4'h0, 1'b0, 1'b0);
      run_test(1'b1, 8'h81, 4'hA, 4'h5, 1'b0, 1'b0);
      run_test(1'b1, '0, 4'h0, 4'h0, 1'b1, 1'b0);
      run_test(1'b0, 8'hA5, 4'h3, 4'hC, 1'b0, 1'b1);
      run_test(1'b1, 8'h3C, 4'h9, 4'h6, 1'b1, 1'b1);
      // random patterns
      for (int t = 0; t < 12; t++) begin
         run_test(1'($urandom), N'($urandom), PW'($urandom), PW'($urandom),
                  1'($urandom), (t % 4) == 3);
      end
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule